// File: doc/BRIEF.md
# Ramp-Driven Section Sum Accumulator

This block runs the offline linearity measurement of a 14-bit DAC under test. When a start pulse arrives it sweeps the DAC through all 16384 input codes, lowest first. For every code it watches the one-bit output of an oversampling sigma-delta modulator that digitises the analog DAC level. It counts the ones seen over a programmable number of modulator clocks, N = 2^k.

The code range is cut into four equal quarters, each 4096 codes wide. The ones count for each code is added into a running sum that belongs to its quarter. These four sums are the raw inputs of a cubic fit of the integral non-linearity. The fit itself is computed elsewhere.

A run is started at power-up, once the digital self-test has finished, and again from time to time while the system is idle. The modulator enable output is high only while a run is in progress. At the end of a run a one-cycle done pulse is raised. The four sums then stay unchanged until the next start.

Top module: `ramp_section_accum`

## Requirements
- R1: After reset, `mod_en_o`, `done_o`, `dac_code_o` and every sum in `sums_o` are zero.
- R2: A high `start_i` at a rising edge clears all four sums and sets `dac_code_o` to 0 and `mod_en_o` to 1 from that edge on. This also applies while a run is in progress, which is then restarted.
- R3: During a run, `dac_code_o` steps up by exactly one, from 0 to 16383. Each code is held for exactly N = 2^k clocks, where k is `osr_sel_i` sampled at the start edge and limited to 6. Changes of `osr_sel_i` after the start edge have no effect.
- R4: `mod_en_o` is high from the start edge until the edge that samples the last modulator bit of code 16383, and low otherwise.
- R5: While `dac_code_o` holds code c, `mod_bit_i` is sampled at each of the N rising edges. The number of ones is added to the sum of section s = c[13:12]. Section s occupies `sums_o[19*s+18 : 19*s]`, so section 0 covers codes 0..4095 in bits 18:0.
- R6: `done_o` is high for exactly one cycle, starting at the edge that samples the last bit of code 16383. At that same edge `mod_en_o` falls.
- R7: When no run is in progress, the sums hold their values until the next start, and `mod_bit_i` has no effect.
- R8: Each 19-bit sum holds the worst case of 4096 × N ones without wrapping, for example 4096 with N = 1 and 16384 with N = 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; begins or restarts a run |
| osr_sel_i | input | 3 | log2 of clocks per code, sampled at start, limited to 6 |
| mod_bit_i | input | 1 | Modulator bitstream |
| dac_code_o | output | 14 | Code driven to the DAC under test |
| mod_en_o | output | 1 | Modulator enable, high during a run |
| done_o | output | 1 | One-cycle end-of-run pulse |
| sums_o | output | 76 | Four 19-bit section sums, section 0 in the low bits |

## Verification
The hardest cases to reach from the ports are a restart in the middle of a run and a change of the clocks-per-code setting during a run. Both need thousands of cycles of ramp before the interesting edge. The bench models the modulator from its own sample index, which gives each bit from the current code and the phase within that code. It pulses start again after 3000 samples and checks that the partial sums vanish. In a separate N = 4 run it alters `osr_sel_i` right after the start edge. Code- and phase-dependent bit patterns give every section a different total, so a misrouted section or a lost final bit shows up in the sums.

// File: rtl/rsa_pkg.sv
package rsa_pkg;
  // Number of code-counter MSBs that select a section.
  localparam int SEC_W   = 2;
  localparam int NUM_SEC = 1 << SEC_W;

  typedef enum logic {
    RUN_IDLE = 1'b0,
    RUN_BUSY = 1'b1
  } run_state_e;
endpackage

// File: rtl/rsa_ramp_seq.sv
// Code ramp and per-code phase sequencer.
module rsa_ramp_seq #(
  parameter int CODE_W    = 14,
  parameter int OSR_MAX   = 6,
  parameter int OSR_SEL_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [OSR_SEL_W-1:0] osr_sel_i,
  output logic [CODE_W-1:0]    code_o,
  output logic                 busy_o,
  output logic                 code_end_o,
  output logic                 done_o
);
  import rsa_pkg::*;

  localparam int PH_W = (OSR_MAX < 1) ? 1 : OSR_MAX;

  run_state_e          state_q, state_d;
  logic [CODE_W-1:0]   code_q, code_d;
  logic [PH_W-1:0]     phase_q, phase_d;
  logic [PH_W-1:0]     mask_q, mask_d;
  logic                done_q, done_d;

  logic [OSR_SEL_W-1:0] eff_sel;
  logic [PH_W:0]        one_hot;
  logic [PH_W:0]        mask_full;
  logic                 code_end;
  logic                 last_code;

  // Limit the selector and turn it into a phase mask (N-1).
  always_comb begin
    eff_sel   = (32'(osr_sel_i) > OSR_MAX) ? OSR_SEL_W'(OSR_MAX) : osr_sel_i;
    one_hot   = (PH_W+1)'(1) << eff_sel;
    mask_full = one_hot - (PH_W+1)'(1);
  end

  assign code_end  = (state_q == RUN_BUSY) && (phase_q == mask_q);
  assign last_code = (code_q == {CODE_W{1'b1}});

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    phase_d = phase_q;
    mask_d  = mask_q;
    done_d  = 1'b0;
    if (start_i) begin
      state_d = RUN_BUSY;
      code_d  = '0;
      phase_d = '0;
      mask_d  = mask_full[PH_W-1:0];
    end else if (state_q == RUN_BUSY) begin
      if (code_end) begin
        phase_d = '0;
        code_d  = code_q + CODE_W'(1);
        if (last_code) begin
          state_d = RUN_IDLE;
          done_d  = 1'b1;
        end
      end else begin
        phase_d = phase_q + PH_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RUN_IDLE;
      code_q  <= '0;
      phase_q <= '0;
      mask_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
      phase_q <= phase_d;
      mask_q  <= mask_d;
      done_q  <= done_d;
    end
  end

  assign code_o     = code_q;
  assign busy_o     = (state_q == RUN_BUSY);
  assign code_end_o = code_end;
  assign done_o     = done_q;
endmodule

// File: rtl/rsa_ones_count.sv
// Counts modulator ones during the clocks of one code.
module rsa_ones_count #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             sample_i,
  input  logic             code_end_i,
  input  logic             bit_i,
  output logic [CNT_W-1:0] total_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] total;

  // Total including the bit sampled at the current edge.
  assign total = cnt_q + CNT_W'(bit_i);

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i) begin
      cnt_d = '0;
    end else if (sample_i) begin
      cnt_d = code_end_i ? '0 : total;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign total_o = total;
endmodule

// File: rtl/rsa_section_bank.sv
// One accumulator per code-range section.
module rsa_section_bank #(
  parameter int NUM_SEC = 4,
  parameter int SEC_W   = 2,
  parameter int ACC_W   = 19,
  parameter int CNT_W   = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear_i,
  input  logic                     add_i,
  input  logic [SEC_W-1:0]         sec_i,
  input  logic [CNT_W-1:0]         count_i,
  output logic [NUM_SEC*ACC_W-1:0] sums_o
);
  for (genvar g = 0; g < NUM_SEC; g++) begin : g_sec
    logic [ACC_W-1:0] acc_q, acc_d;

    always_comb begin
      acc_d = acc_q;
      if (clear_i) begin
        acc_d = '0;
      end else if (add_i && (sec_i == SEC_W'(g))) begin
        acc_d = acc_q + ACC_W'(count_i);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q <= '0;
      end else begin
        acc_q <= acc_d;
      end
    end

    assign sums_o[g*ACC_W +: ACC_W] = acc_q;
  end
endmodule

// File: rtl/ramp_section_accum.sv
module ramp_section_accum #(
  parameter int CODE_W    = 14,
  parameter int OSR_MAX   = 6,
  parameter int OSR_SEL_W = $clog2(OSR_MAX + 1),
  parameter int ACC_W     = CODE_W - rsa_pkg::SEC_W + OSR_MAX + 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start_i,
  input  logic [OSR_SEL_W-1:0]               osr_sel_i,
  input  logic                               mod_bit_i,
  output logic [CODE_W-1:0]                  dac_code_o,
  output logic                               mod_en_o,
  output logic                               done_o,
  output logic [rsa_pkg::NUM_SEC*ACC_W-1:0]  sums_o
);
  localparam int SEC_W   = rsa_pkg::SEC_W;
  localparam int NUM_SEC = rsa_pkg::NUM_SEC;
  localparam int CNT_W   = OSR_MAX + 1;

  logic              busy;
  logic              code_end;
  logic [CODE_W-1:0] code;
  logic [CNT_W-1:0]  code_total;

  rsa_ramp_seq #(
    .CODE_W    (CODE_W),
    .OSR_MAX   (OSR_MAX),
    .OSR_SEL_W (OSR_SEL_W)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .osr_sel_i  (osr_sel_i),
    .code_o     (code),
    .busy_o     (busy),
    .code_end_o (code_end),
    .done_o     (done_o)
  );

  rsa_ones_count #(
    .CNT_W (CNT_W)
  ) cnt_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (start_i),
    .sample_i   (busy),
    .code_end_i (code_end),
    .bit_i      (mod_bit_i),
    .total_o    (code_total)
  );

  rsa_section_bank #(
    .NUM_SEC (NUM_SEC),
    .SEC_W   (SEC_W),
    .ACC_W   (ACC_W),
    .CNT_W   (CNT_W)
  ) bank_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_i),
    .add_i   (code_end),
    .sec_i   (code[CODE_W-1 -: SEC_W]),
    .count_i (code_total),
    .sums_o  (sums_o)
  );

  assign dac_code_o = code;
  assign mod_en_o   = busy;
endmodule

// File: rtl/rsa_checker.sv
module rsa_checker #(
  parameter int CODE_W  = 14,
  parameter int ACC_W   = 19,
  parameter int NUM_SEC = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start_i,
  input logic                     mod_en_o,
  input logic                     done_o,
  input logic [CODE_W-1:0]        dac_code_o,
  input logic [NUM_SEC*ACC_W-1:0] sums_o
);
  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (mod_en_o && (dac_code_o == '0) && (sums_o == '0)));

  assert_code_steps_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en_o && $past(mod_en_o) && !$past(start_i) && (dac_code_o != $past(dac_code_o)))
      |-> (dac_code_o == $past(dac_code_o) + CODE_W'(1)));

  assert_enable_falls_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_en_o) |-> (done_o && ($past(dac_code_o) == {CODE_W{1'b1}})));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mod_en_o);

  assert_sums_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_en_o && !start_i) |=> $stable(sums_o));
endmodule

bind ramp_section_accum rsa_checker #(
  .CODE_W  (CODE_W),
  .ACC_W   (ACC_W),
  .NUM_SEC (NUM_SEC)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .mod_en_o   (mod_en_o),
  .done_o     (done_o),
  .dac_code_o (dac_code_o),
  .sums_o     (sums_o)
);

// File: tb/ramp_section_accum_tb.sv
`timescale 1ns/1ps
module ramp_section_accum_tb_top;
  localparam int CODE_W  = 14;
  localparam int ACC_W   = 19;
  localparam int NSEC    = 4;
  localparam int NCODES  = 1 << CODE_W;

  logic                   clk;
  logic                   rst_n;
  logic                   start_i;
  logic [2:0]             osr_sel_i;
  logic                   mod_bit_i;
  logic [CODE_W-1:0]      dac_code_o;
  logic                   mod_en_o;
  logic                   done_o;
  logic [NSEC*ACC_W-1:0]  sums_o;

  int n_cmp;
  int n_bad;
  logic [ACC_W-1:0] exp_q[$];

  ramp_section_accum dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .osr_sel_i  (osr_sel_i),
    .mod_bit_i  (mod_bit_i),
    .dac_code_o (dac_code_o),
    .mod_en_o   (mod_en_o),
    .done_o     (done_o),
    .sums_o     (sums_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [ACC_W-1:0] sum_of(input int s);
    return sums_o[s*ACC_W +: ACC_W];
  endfunction

  // Modulator model: bit from code and phase within the code.
  function automatic logic pat(input int pid, input int code, input int ph);
    case (pid)
      0:       return 1'b1;
      1:       return logic'(((code >> 0) ^ (code >> 7) ^ (code >> 13)) & 1);
      default: return logic'((ph < (code & 3)) || (((code >> 12) & 1) == 1 && ph == 3));
    endcase
  endfunction

  // Driver: runs one pass, checks the ramp, pushes expected sums.
  task automatic run_pass(input int lg, input int pid, input int abort_at, input int osr_after);
    int n;
    longint expv[NSEC];
    n = 1 << lg;
    for (int s = 0; s < NSEC; s++) expv[s] = 0;
    @(negedge clk);
    osr_sel_i = 3'(lg);
    start_i   = 1'b1;
    mod_bit_i = 1'b0;
    @(negedge clk);
    start_i   = 1'b0;
    osr_sel_i = 3'(osr_after);
    check(mod_en_o == 1'b1, "R2 mod_en after start", mod_en_o, 1);
    check(dac_code_o == 0, "R2 code after start", dac_code_o, 0);
    check(sums_o == '0, "R2 sums after start", 0, 0);
    if (abort_at > 0) begin
      for (int s = 0; s < abort_at; s++) begin
        mod_bit_i = 1'b1;
        @(negedge clk);
      end
      check(sum_of(0) != 0, "R5 partial sum before restart", sum_of(0), 1);
      start_i   = 1'b1;
      osr_sel_i = 3'(lg);
      @(negedge clk);
      start_i   = 1'b0;
      osr_sel_i = 3'(osr_after);
      check(sums_o == '0, "R2 restart clears sums", sum_of(0), 0);
      check(dac_code_o == 0, "R2 restart code", dac_code_o, 0);
    end
    for (int s = 0; s < n * NCODES; s++) begin
      int c;
      int ph;
      logic b;
      c  = s >> lg;
      ph = s & (n - 1);
      if (dac_code_o != CODE_W'(c) || mod_en_o != 1'b1)
        check(1'b0, "R3 ramp code", dac_code_o, c);
      else
        n_cmp++;
      if (done_o) check(1'b0, "R6 early done", 1, 0);
      b = pat(pid, c, ph);
      mod_bit_i = b;
      expv[c >> 12] += longint'(b);
      if (s == n * NCODES - 1) begin
        for (int k = 0; k < NSEC; k++) exp_q.push_back(ACC_W'(expv[k]));
      end
      @(negedge clk);
    end
    check(done_o == 1'b1, "R6 done after last code", done_o, 1);
    check(mod_en_o == 1'b0, "R4 mod_en low after run", mod_en_o, 0);
    if (pid == 0)
      check(sum_of(3) == ACC_W'(4096 * n), "R8 full-scale section", sum_of(3), 4096 * n);
    begin
      logic [NSEC*ACC_W-1:0] held;
      held = sums_o;
      @(negedge clk);
      check(done_o == 1'b0, "R6 done one cycle", done_o, 0);
      for (int t = 0; t < 20; t++) begin
        mod_bit_i = ~mod_bit_i;
        @(negedge clk);
      end
      check(sums_o == held, "R7 sums held while idle", sum_of(0), held[ACC_W-1:0]);
      check(mod_en_o == 1'b0, "R4 mod_en stays low", mod_en_o, 0);
    end
  endtask

  // Monitor: compares sums when done is seen.
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() < NSEC) begin
        check(1'b0, "R5 unexpected done", exp_q.size(), NSEC);
      end else begin
        for (int s = 0; s < NSEC; s++) begin
          logic [ACC_W-1:0] e;
          e = exp_q.pop_front();
          check(sum_of(s) == e, "R5 section sum", sum_of(s), e);
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp = 0;
    n_bad = 0;
    rst_n = 1'b0;
    start_i = 1'b0;
    osr_sel_i = 3'd0;
    mod_bit_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(mod_en_o == 1'b0, "R1 reset mod_en", mod_en_o, 0);
    check(done_o == 1'b0, "R1 reset done", done_o, 0);
    check(dac_code_o == 0, "R1 reset code", dac_code_o, 0);
    check(sums_o == '0, "R1 reset sums", sum_of(0), 0);
    // R7: bits while idle leave the sums at zero.
    mod_bit_i = 1'b1;
    repeat (5) @(negedge clk);
    check(sums_o == '0, "R7 idle bits ignored", sum_of(0), 0);

    run_pass(0, 0, 0, 0);      // R8, N = 1 all ones
    run_pass(0, 1, 3000, 0);   // R2 restart mid-run, R5 pattern
    run_pass(2, 2, 0, 5);      // R3 N = 4, selector change ignored

    check(exp_q.size() == 0, "R6 all runs reported done", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule